// File: doc/BRIEF.md
# Counter Bit-Transition Event Generator

The block watches a free-running 64-bit count value and raises a one-clock event pulse whenever one chosen low-order bit of that count changes in a chosen direction. The pulse feeds wait-for-event logic elsewhere in the chip. Three control fields shape the pulse stream:
- a 4-bit tap select names the trigger bit, from 0 to 15;
- a direction flag picks whether a rising or a falling change counts;
- an enable gates the whole stream.

All three are held in a small control register that loads on a write strobe.

Any write to the control register reloads the edge history from the newly selected bit on the count value present in that cycle. Retargeting the tap or flipping the direction therefore never produces a false pulse. Enabling the stream can only report edges that occur after the write. Count bits above the tap range never influence the output.

Top module: `cnt_edge_event`

## Requirements
- R1: The control register's tap select value N (0..15, unsigned binary) makes count bit N the trigger bit. Changes on any other bit of the low 16 do not produce events.
- R2: With direction flag 0, a change of the trigger bit from 0 in one cycle to 1 in the next produces an event, and a 1-to-0 change does not.
- R3: With direction flag 1, a change of the trigger bit from 1 to 0 produces an event, and a 0-to-1 change does not.
- R4: While the enable held in the control register is 0, event_o stays 0 whatever the count does.
- R5: An event is a pulse of exactly one clock on event_o. It goes high right after the clock edge at which the count value that completes the qualifying change is sampled.
- R6: In a cycle where ctl_wr_i is 1, no event is produced. The edge history is reloaded from the newly selected bit of that cycle's count, so changing the tap select or direction causes no spurious event.
- R7: After a write that sets enable to 1, the first event can only come from a change seen in a later cycle than the write.
- R8: Reset clears the tap select, direction and enable fields to 0 and holds event_o at 0. Without a write after reset, no event is produced.
- R9: Count bits 16 to 63 have no effect on event_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_i | input | 64 | Free-running count value |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_sel_i | input | 4 | Tap select to be written (trigger bit index) |
| ctl_fall_i | input | 1 | Direction to be written: 0 rising, 1 falling |
| ctl_en_i | input | 1 | Enable to be written |
| event_o | output | 1 | One-clock event pulse |

## Verification
An event is due one clock after the qualifying count value is sampled. It rises just after that same edge because only the event flop lies on the path. A control write takes effect at the edge where it is sampled, and reset release adds two cycles before writes are accepted. The bench drives every input at the falling clock edge and samples event_o one time unit after the following rising edge. Its model updates its own copy of the control fields and of the edge history at that same edge, so each vector compares one cycle's expected pulse against the flop loaded by that cycle's inputs.

// File: rtl/cnt_edge_event_pkg.sv
package cnt_edge_event_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_dir_e;

  function automatic logic edge_seen(input logic prev_bit, input logic cur_bit,
                                     input edge_dir_e dir);
    logic hit;
    if (dir == EDGE_FALL) hit = prev_bit & ~cur_bit;
    else                  hit = ~prev_bit & cur_bit;
    return hit;
  endfunction

endpackage

// File: rtl/cnt_edge_event_rst_sync.sv
module cnt_edge_event_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cnt_edge_event_ctl.sv
module cnt_edge_event_ctl #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fall_i,
  input  logic             en_i,
  output logic [SEL_W-1:0] sel_q,
  output logic             fall_q,
  output logic             en_q
);

  logic [SEL_W-1:0] sel_d;
  logic             fall_d;
  logic             en_d;

  always_comb begin
    sel_d  = sel_q;
    fall_d = fall_q;
    en_d   = en_q;
    if (wr_i) begin
      sel_d  = sel_i;
      fall_d = fall_i;
      en_d   = en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      fall_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      fall_q <= fall_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/cnt_edge_event_tap.sv
module cnt_edge_event_tap #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned TAP_N = 1 << SEL_W
) (
  input  logic [TAP_N-1:0] taps_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);

  logic [TAP_N-1:0] pick_vec;

  for (genvar i = 0; i < TAP_N; i++) begin : g_pick
    assign pick_vec[i] = taps_i[i] & (sel_i == SEL_W'(i));
  end

  assign bit_o = |pick_vec;

endmodule

// File: rtl/cnt_edge_event_det.sv
module cnt_edge_event_det
  import cnt_edge_event_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur_bit_i,
  input  logic load_i,
  input  logic load_bit_i,
  input  logic en_i,
  input  logic fall_i,
  output logic evt_o
);

  logic prev_q, prev_d;
  logic evt_q, evt_d;
  edge_dir_e dir;

  always_comb begin
    dir    = fall_i ? EDGE_FALL : EDGE_RISE;
    prev_d = load_i ? load_bit_i : cur_bit_i;
    evt_d  = en_i & ~load_i & edge_seen(prev_q, cur_bit_i, dir);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/cnt_edge_event.sv
module cnt_edge_event #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ctl_wr_i,
  input  logic [SEL_W-1:0] ctl_sel_i,
  input  logic             ctl_fall_i,
  input  logic             ctl_en_i,
  output logic             event_o
);

  localparam int unsigned TAP_N = 1 << SEL_W;

  logic             rst_n_int;
  logic [SEL_W-1:0] sel_q;
  logic             fall_q;
  logic             en_q;
  logic             cur_bit;
  logic             new_bit;
  logic             wr_live;
  logic [TAP_N-1:0] taps;

  assign taps = cnt_i[TAP_N-1:0];

  if (CNT_W > TAP_N) begin : g_hi
    logic unused_hi_bits;
    assign unused_hi_bits = ^cnt_i[CNT_W-1:TAP_N];
  end

  cnt_edge_event_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign wr_live = ctl_wr_i & rst_n_int;

  cnt_edge_event_ctl #(.SEL_W(SEL_W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_i   (wr_live),
    .sel_i  (ctl_sel_i),
    .fall_i (ctl_fall_i),
    .en_i   (ctl_en_i),
    .sel_q  (sel_q),
    .fall_q (fall_q),
    .en_q   (en_q)
  );

  cnt_edge_event_tap #(.SEL_W(SEL_W)) u_tap_cur (
    .taps_i (taps),
    .sel_i  (sel_q),
    .bit_o  (cur_bit)
  );

  cnt_edge_event_tap #(.SEL_W(SEL_W)) u_tap_new (
    .taps_i (taps),
    .sel_i  (ctl_sel_i),
    .bit_o  (new_bit)
  );

  cnt_edge_event_det u_det (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cur_bit_i  (cur_bit),
    .load_i     (wr_live),
    .load_bit_i (new_bit),
    .en_i       (en_q),
    .fall_i     (fall_q),
    .evt_o      (event_o)
  );

endmodule

// File: rtl/cnt_edge_event_chk.sv
module cnt_edge_event_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wr_i,
  input logic [SEL_W-1:0] sel_q,
  input logic             fall_q,
  input logic             en_q,
  input logic             event_o
);

  logic [CNT_W-1:0] cnt_prev_q;
  logic             was_bit;
  logic             now_bit;
  logic             qual_rise;
  logic             qual_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev_q <= '0;
    else        cnt_prev_q <= cnt_i;
  end

  assign was_bit   = cnt_prev_q[sel_q];
  assign now_bit   = cnt_i[sel_q];
  assign qual_rise = en_q && !wr_i && !fall_q && !was_bit && now_bit;
  assign qual_fall = en_q && !wr_i && fall_q && was_bit && !now_bit;

  assert_rise_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_rise |=> event_o);

  assert_fall_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qual_fall |=> event_o);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !event_o);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !event_o);

  assert_event_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(qual_rise || qual_fall));

endmodule

bind cnt_edge_event cnt_edge_event_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_i   (cnt_i),
  .wr_i    (ctl_wr_i),
  .sel_q   (sel_q),
  .fall_q  (fall_q),
  .en_q    (en_q),
  .event_o (event_o)
);

// File: tb/cnt_edge_event_test.sv
module cnt_edge_event_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [63:0] cnt_i = '0;
  logic        ctl_wr_i = 1'b0;
  logic [3:0]  ctl_sel_i = '0;
  logic        ctl_fall_i = 1'b0;
  logic        ctl_en_i = 1'b0;
  logic        event_o;

  int n_vec = 0;
  int n_bad = 0;
  int n_evt = 0;
  bit done = 1'b0;

  int   m_sel = 0;
  bit   m_fall = 1'b0;
  bit   m_en = 1'b0;
  bit   m_prev = 1'b0;
  logic [63:0] seed = 64'h1234_5678_9abc_def0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cnt_edge_event uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_sel_i  (ctl_sel_i),
    .ctl_fall_i (ctl_fall_i),
    .ctl_en_i   (ctl_en_i),
    .event_o    (event_o)
  );

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: event_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [63:0] c, input bit w, input int s, input bit f,
                     input bit e, input string req);
    bit cur;
    bit exp;
    @(negedge clk);
    cnt_i      = c;
    ctl_wr_i   = w;
    ctl_sel_i  = 4'(s);
    ctl_fall_i = f;
    ctl_en_i   = e;
    cur = c[m_sel];
    exp = m_en && !w && (m_fall ? (m_prev && !cur) : (!m_prev && cur));
    if (w) begin
      m_sel  = s;
      m_fall = f;
      m_en   = e;
      m_prev = c[s];
    end else begin
      m_prev = cur;
    end
    @(posedge clk);
    #1;
    if (event_o === 1'b1) n_evt++;
    check(event_o, exp, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] c;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(event_o, 1'b0, "R8 reset");
    repeat (3) @(posedge clk);

    // R8: no write after reset -> fields 0, stream off, every bit toggling
    for (int k = 0; k < 6; k++)
      cyc((k % 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0, 0, 0, 0, 0, "R8 idle");

    // R4: written with enable 0, bit 0 toggling
    cyc(64'h0, 1, 0, 0, 0, "R4 write");
    for (int k = 1; k < 9; k++) cyc(64'(k), 0, 0, 0, 0, "R4");

    // R5: incrementing count, tap 0 rising -> pulse every other cycle
    cyc(64'h0, 1, 0, 0, 1, "R5 write");
    n_evt = 0;
    for (int k = 1; k < 9; k++) cyc(64'(k), 0, 0, 0, 1, "R5");
    check_int(n_evt, 4, "R5 pulse count");

    // R1 R2 R3: sweep every tap and both directions
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 2; f++) begin
        c = next_rand();
        c[s] = 1'b0;
        cyc(c, 1, s, f[0], 1, "R1 write");
        n_evt = 0;
        for (int k = 1; k < 24; k++) begin
          c = next_rand();
          c[s] = k[1];
          cyc(c, 0, s, f[0], 1, f ? "R3" : "R2");
        end
        // bit pattern 0,0,1,1,... : rises at k=2,6,..,22, falls at k=4,..,20
        check_int(n_evt, f ? 5 : 6, f ? "R3 R1 count" : "R2 R1 count");
      end
      // R1 R9: trigger bit held 0, neighbour and high bits toggling
      cyc(64'h0, 1, s, 0, 1, "R1 write");
      n_evt = 0;
      for (int k = 1; k < 9; k++) begin
        c = next_rand();
        c[15:0] = '0;
        c[(s + 1) % 16] = k[0];
        cyc(c, 0, s, 0, 1, "R1 R9");
      end
      check_int(n_evt, 0, "R1 R9 other bits");
    end

    // R9: only bits 16..63 move, falling mode, trigger bit held 1
    cyc(64'h0000_0000_0000_8000, 1, 15, 1, 1, "R9 write");
    for (int k = 0; k < 8; k++)
      cyc({next_rand() >> 16, 16'h8000}, 0, 15, 1, 1, "R9");

    // R6: retarget from a 0 bit to a 1 bit in rising mode: no event
    cyc(64'h0000_0000_0000_0020, 1, 0, 0, 1, "R6 write");
    cyc(64'h0000_0000_0000_0020, 0, 0, 0, 1, "R6");
    cyc(64'h0000_0000_0000_0020, 1, 5, 0, 1, "R6 sel change");
    cyc(64'h0000_0000_0000_0020, 0, 5, 0, 1, "R6 after sel");
    // R6: flip direction while bit 5 sits at 1, then retarget to a 0 bit
    cyc(64'h0000_0000_0000_0020, 1, 5, 1, 1, "R6 dir change");
    cyc(64'h0000_0000_0000_0020, 0, 5, 1, 1, "R6 after dir");
    cyc(64'h0000_0000_0000_0020, 1, 0, 1, 1, "R6 sel to 0 bit");
    cyc(64'h0000_0000_0000_0020, 0, 0, 1, 1, "R6 after sel");
    // R6: a write in the very cycle the old trigger bit rises gives no event
    cyc(64'h0, 1, 3, 0, 1, "R6 write");
    cyc(64'h8, 1, 3, 0, 1, "R6 edge on write");
    cyc(64'h8, 0, 3, 0, 1, "R6 after");
    cyc(64'h0, 0, 3, 0, 1, "R6 fall ignored");
    cyc(64'h8, 0, 3, 0, 1, "R6 R2 later rise");

    // R7: stream off while bit rises, enable written on a rising cycle
    cyc(64'h0, 1, 2, 0, 0, "R7 off");
    cyc(64'h4, 0, 2, 0, 0, "R7 off rise");
    cyc(64'h0, 0, 2, 0, 0, "R7 off");
    cyc(64'h4, 1, 2, 0, 1, "R7 enable on rise");
    cyc(64'h4, 0, 2, 0, 1, "R7 held");
    cyc(64'h0, 0, 2, 0, 1, "R7 fall");
    cyc(64'h4, 0, 2, 0, 1, "R7 first rise");
    cyc(64'h4, 0, 2, 0, 1, "R7 R5 pulse ends");

    done = 1'b1;
    finish_run();
  end

endmodule